// File: doc/BRIEF.md
# Priority Memory Arbiter with Stall Escalation

This block decides, cycle by cycle, which of three requesters may use a single shared memory port: a sensor-controller port (index 0), system-bus port A (index 1) and system-bus port B (index 2). Each requester drives a request line and receives a grant line in the same cycle. A grant means the access is taken in that cycle. A requester that keeps its request high after a grant is presenting the next access of a burst.

Each requester has a 2-bit priority code and a 4-bit stall limit. Both come from configuration inputs. A per-requester counter records how many consecutive cycles the requester has been refused. Once that count reaches the limit, the requester is lifted to an escalated level that sits above the high level. This bounds how long a low-priority port can be starved. The counter clears on every grant, so each access of a burst has its own wait budget. The winner is also presented on the memory side as a valid flag plus an index.

Top module: `prio_mem_arb`

## Requirements
- R1: While `rst` is high, no grant is asserted and `mem_req_o` is low, whatever the requests.
- R2: At most one bit of `grant_o` is high in any cycle, and a grant bit is high only when the matching request bit is high.
- R3: When at least one request is high (outside reset), exactly one grant is given. With no request, no grant is given.
- R4: Priority code decoding, 2 bits per requester at `cfg_prio_i[2i+1:2i]`: 00 is low, 01 is mid, and 1x (10 or 11) is high. A requester at a higher level beats one at a lower level.
- R5: Requesters at the same level are resolved in fixed order: index 0 first, then index 1, then index 2.
- R6: A requester's stall count rises by one in each cycle it requests and is not granted. When the count is at or above its 4-bit limit (`cfg_stall_i[4i+3:4i]`), the requester is escalated above the high level.
- R7: The stall count clears on a grant. The next access of a burst therefore waits its full limit again before it escalates.
- R8: The stall count clears in any cycle the requester's request is low.
- R9: A stall limit of 0 makes a requesting port escalated at once, in every cycle it requests.
- R10: When several requesters are escalated together, the fixed order of R5 decides between them.
- R11: `mem_req_o` is high exactly when a grant is given. `mem_idx_o` then carries the binary index (0, 1 or 2) of the granted requester.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_REQ (3) | Request per requester; bit 0 sensor port, bit 1 bus A, bit 2 bus B |
| cfg_prio_i | input | 2*NUM_REQ (6) | Priority code per requester, 2 bits each |
| cfg_stall_i | input | STALL_W*NUM_REQ (12) | Maximum stall cycles per requester, 4 bits each |
| grant_o | output | NUM_REQ (3) | One-hot grant, same cycle as the request |
| mem_req_o | output | 1 | Memory-side access valid |
| mem_idx_o | output | IDX_W (2) | Index of the granted requester |

## Verification
The pure priority function is exercised from a table of request and priority patterns. Counters are cleared before every pattern, so no escalation is involved. These patterns separate level ordering, the treatment of both 1x codes as high, tie order, and masking of non-requesting ports. Timed sequences then hold a low-priority port against a high-priority one. These show that the grant moves to the low port on exactly the cycle its count reaches the limit, and that the count restarts after each granted beat and after a dropped request. A further sequence with two ports escalating together, and one with a zero limit, separates escalation order from plain tie order.

// File: rtl/prio_arb_pkg.sv
package prio_arb_pkg;

    localparam int NUM_REQ_DEF = 3;
    localparam int PRIO_W      = 2;
    localparam int STALL_W_DEF = 4;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'd0,
        LVL_MID  = 2'd1,
        LVL_HIGH = 2'd2,
        LVL_ESC  = 2'd3
    } level_e;

    typedef struct packed {
        logic   active;
        level_e lvl;
    } bid_t;

    function automatic level_e decode_prio(input logic [PRIO_W-1:0] code);
        level_e l;
        if (code[1])
            l = LVL_HIGH;
        else if (code[0])
            l = LVL_MID;
        else
            l = LVL_LOW;
        return l;
    endfunction

endpackage

// File: rtl/prio_arb_stall_ctr.sv
module prio_arb_stall_ctr #(
    parameter int STALL_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req,
    input  logic               granted,
    input  logic [STALL_W-1:0] limit,
    output logic               escalated
);

    localparam logic [STALL_W-1:0] CNT_MAX = {STALL_W{1'b1}};

    logic [STALL_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (!req || granted)
            cnt_q <= '0;
        else if (cnt_q != CNT_MAX)
            cnt_q <= cnt_q + 1'b1;
    end

    assign escalated = req && (cnt_q >= limit);

endmodule

// File: rtl/prio_arb_level_map.sv
module prio_arb_level_map
    import prio_arb_pkg::*;
(
    input  logic              req,
    input  logic [PRIO_W-1:0] prio,
    input  logic              escalated,
    output bid_t              bid
);

    always_comb begin
        bid.active = req;
        if (escalated)
            bid.lvl = LVL_ESC;
        else
            bid.lvl = decode_prio(prio);
    end

endmodule

// File: rtl/prio_arb_pick.sv
module prio_arb_pick
    import prio_arb_pkg::*;
#(
    parameter int NUM_REQ = 3,
    parameter int IDX_W   = 2
) (
    input  bid_t [NUM_REQ-1:0] bids,
    output logic [NUM_REQ-1:0] grant,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);

    level_e best_lvl;

    always_comb begin
        any      = 1'b0;
        idx      = '0;
        best_lvl = LVL_LOW;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (bids[i].active && (!any || (bids[i].lvl > best_lvl))) begin
                any      = 1'b1;
                idx      = IDX_W'(i);
                best_lvl = bids[i].lvl;
            end
        end
        grant = '0;
        if (any)
            grant[idx] = 1'b1;
    end

endmodule

// File: rtl/prio_mem_arb.sv
module prio_mem_arb
    import prio_arb_pkg::*;
#(
    parameter int NUM_REQ = NUM_REQ_DEF,
    parameter int STALL_W = STALL_W_DEF,
    localparam int IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_REQ-1:0]         req_i,
    input  logic [NUM_REQ*PRIO_W-1:0]  cfg_prio_i,
    input  logic [NUM_REQ*STALL_W-1:0] cfg_stall_i,
    output logic [NUM_REQ-1:0]         grant_o,
    output logic                       mem_req_o,
    output logic [IDX_W-1:0]           mem_idx_o
);

    bid_t [NUM_REQ-1:0] bids;
    logic [NUM_REQ-1:0] esc;
    logic [NUM_REQ-1:0] pick_grant;
    logic               pick_any;
    logic [IDX_W-1:0]   pick_idx;

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_port
        prio_arb_stall_ctr #(.STALL_W(STALL_W)) u_ctr (
            .clk       (clk),
            .rst       (rst),
            .req       (req_i[g]),
            .granted   (grant_o[g]),
            .limit     (cfg_stall_i[g*STALL_W +: STALL_W]),
            .escalated (esc[g])
        );

        prio_arb_level_map u_map (
            .req       (req_i[g]),
            .prio      (cfg_prio_i[g*PRIO_W +: PRIO_W]),
            .escalated (esc[g]),
            .bid       (bids[g])
        );
    end

    prio_arb_pick #(.NUM_REQ(NUM_REQ), .IDX_W(IDX_W)) u_pick (
        .bids  (bids),
        .grant (pick_grant),
        .any   (pick_any),
        .idx   (pick_idx)
    );

    assign grant_o   = rst ? '0 : pick_grant;
    assign mem_req_o = !rst && pick_any;
    assign mem_idx_o = pick_idx;

endmodule

// File: rtl/prio_mem_arb_chk.sv
module prio_mem_arb_chk #(
    parameter int NUM_REQ = 3,
    parameter int STALL_W = 4,
    parameter int IDX_W   = 2
) (
    input logic                       clk,
    input logic                       rst,
    input logic [NUM_REQ-1:0]         req_i,
    input logic [NUM_REQ*STALL_W-1:0] cfg_stall_i,
    input logic [NUM_REQ-1:0]         grant_o,
    input logic                       mem_req_o,
    input logic [IDX_W-1:0]           mem_idx_o
);

    logic [STALL_W-1:0] wait0_q;

    always_ff @(posedge clk) begin
        if (rst)
            wait0_q <= '0;
        else if (!req_i[0] || grant_o[0])
            wait0_q <= '0;
        else if (wait0_q != {STALL_W{1'b1}})
            wait0_q <= wait0_q + 1'b1;
    end

    always @(posedge clk) begin
        if (rst) begin
            AST_RESET_QUIET: assert (grant_o == '0 && !mem_req_o); // R1
        end
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o)); // R2

    AST_GRANT_REQUESTED: assert property (@(posedge clk) disable iff (rst)
        (grant_o & ~req_i) == '0); // R2

    AST_NO_IDLE: assert property (@(posedge clk) disable iff (rst)
        (|req_i) |-> (|grant_o)); // R3

    AST_IDX_AGREES: assert property (@(posedge clk) disable iff (rst)
        mem_req_o |-> grant_o[mem_idx_o]); // R11

    AST_VALID_MATCH: assert property (@(posedge clk) disable iff (rst)
        mem_req_o == (|grant_o)); // R11

    AST_ESC_TOP: assert property (@(posedge clk) disable iff (rst)
        (req_i[0] && (wait0_q >= cfg_stall_i[STALL_W-1:0])) |-> grant_o[0]); // R6

endmodule

bind prio_mem_arb prio_mem_arb_chk #(
    .NUM_REQ (NUM_REQ),
    .STALL_W (STALL_W),
    .IDX_W   (IDX_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_i       (req_i),
    .cfg_stall_i (cfg_stall_i),
    .grant_o     (grant_o),
    .mem_req_o   (mem_req_o),
    .mem_idx_o   (mem_idx_o)
);

// File: tb/prio_mem_arb_tb.sv
module prio_mem_arb_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  req_i = '0;
    logic [5:0]  cfg_prio_i = '0;
    logic [11:0] cfg_stall_i = 12'hFFF;
    logic [2:0]  grant_o;
    logic        mem_req_o;
    logic [1:0]  mem_idx_o;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    prio_mem_arb u_dut (
        .clk         (clk),
        .rst         (rst),
        .req_i       (req_i),
        .cfg_prio_i  (cfg_prio_i),
        .cfg_stall_i (cfg_stall_i),
        .grant_o     (grant_o),
        .mem_req_o   (mem_req_o),
        .mem_idx_o   (mem_idx_o)
    );

    // {req[2:0], prio {B,A,S}, expected grant}
    localparam logic [11:0] VEC [8] = '{
        12'b111_000000_001,   // R5 all low, sensor first
        12'b110_000000_010,   // R5 bus A before bus B
        12'b111_000100_010,   // R4 mid beats low
        12'b100101_100 | 12'b111_000000_000, // R4 high beats mid
        12'b111_111000_010,   // R4 both 1x high, tie to A
        12'b101_011100_100,   // R2 A idle though high
        12'b000_000000_000,   // R3 no request
        12'b011_001111_001    // R5 S and A high, S first
    };

    function automatic logic [1:0] oh2idx(input logic [2:0] oh);
        if (oh[2]) return 2'd2;
        if (oh[1]) return 2'd1;
        return 2'd0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_cycle();
        @(negedge clk);
        req_i = '0;
    endtask

    task automatic seq_step(input logic [2:0] r, input logic [2:0] exp, input string tag);
        @(negedge clk);
        req_i = r;
        #1;
        chk(tag, {29'd0, grant_o}, {29'd0, exp});
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1 reset state with all requests high
        req_i = 3'b111;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 grant in reset", {29'd0, grant_o}, 32'd0);
        chk("R1 mem_req in reset", {31'd0, mem_req_o}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        req_i = '0;

        // table of pure priority patterns (R2 R3 R4 R5 R11)
        cfg_stall_i = 12'hFFF;
        for (int k = 0; k < 8; k++) begin
            clear_cycle();
            @(negedge clk);
            req_i      = VEC[k][11:9];
            cfg_prio_i = VEC[k][8:3];
            #1;
            chk($sformatf("R4/R5 vec%0d grant", k), {29'd0, grant_o}, {29'd0, VEC[k][2:0]});
            chk($sformatf("R11 vec%0d valid", k), {31'd0, mem_req_o}, {31'd0, |VEC[k][2:0]});
            if (|VEC[k][2:0])
                chk($sformatf("R11 vec%0d idx", k), {30'd0, mem_idx_o}, {30'd0, oh2idx(VEC[k][2:0])});
        end

        // R6 R7: sensor low limit 3 against high bus B
        clear_cycle();
        cfg_prio_i  = 6'b100000;
        cfg_stall_i = 12'hFF3;
        for (int c = 0; c < 8; c++)
            seq_step(3'b101, (c % 4 == 3) ? 3'b001 : 3'b100, $sformatf("R6/R7 cycle%0d", c));

        // R8: dropped request restarts the count
        clear_cycle();
        seq_step(3'b101, 3'b100, "R8 pre0");
        seq_step(3'b101, 3'b100, "R8 pre1");
        seq_step(3'b100, 3'b100, "R8 drop");
        for (int c = 0; c < 4; c++)
            seq_step(3'b101, (c == 3) ? 3'b001 : 3'b100, $sformatf("R8 resume%0d", c));

        // R9: limit 0 escalates at once
        clear_cycle();
        cfg_stall_i = 12'hFF0;
        for (int c = 0; c < 4; c++)
            seq_step(3'b101, 3'b001, $sformatf("R9 cycle%0d", c));

        // R10: A and B escalate together against high sensor
        clear_cycle();
        cfg_prio_i  = 6'b000010;
        cfg_stall_i = 12'h22F;
        begin
            logic [2:0] exp_r10 [7] = '{3'b001, 3'b001, 3'b010, 3'b100, 3'b001, 3'b010, 3'b100};
            for (int c = 0; c < 7; c++)
                seq_step(3'b111, exp_r10[c], $sformatf("R10 cycle%0d", c));
        end

        clear_cycle();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule